// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block drives a byte-oriented I2C master whose progress is reported as one-byte status codes. The host hands over one complete message: a device address (seven or ten bits), a direction, a byte count and, for writes, a stream of bytes. The block then answers every status event from the controller without further host help. It writes address or data bytes into the controller's data register. It writes the controller's control word with the enable, start, stop and acknowledge bits. It picks up received bytes, and at the end it raises a one-cycle done pulse together with a result code.

The block builds ten-bit addresses as a two-byte header. On reads it withholds the acknowledge before the final byte, so that byte is answered with NACK. A read of zero bytes acts as a device probe. An abort request stops a write after the current byte and turns a read towards its last byte. A status code that fits no legal step forces a STOP, a controller soft reset and an I/O error.

Every output is registered. A start request or a status event sampled at a clock edge shows up on the outputs in the cycle after that edge. Pulse outputs last one cycle.

Top module: `i2c_msg_seq`

## Requirements
- R1: For a seven-bit address, the first address byte is {devAddr[6:0], readDir}, where readDir = 1 means read.
- R2: With tenBit set, the first address byte is 8'hF0 | (devAddr[9:8] << 1) | readDir. The second byte, devAddr[7:0], is written on status 8'h18 or 8'h40.
- R3: A start request while idle produces a control write of 4'b1101 one cycle later. The control word is {enable[3], start[2], stop[1], ack[0]}. The block becomes busy and clears errCode to 0. A start request while busy is ignored.
- R4: Status 8'h08 or 8'h10 writes the first address byte with the control word {1,0,0,ack}.
- R5: Write acknowledge (8'h18 with seven-bit addressing, 8'hD0, 8'h28) sends the next byte, raising txPop with the data write. It issues STOP with done instead when no bytes remain, or when an abort is pending and at least one data byte has been sent.
- R6: Read address acknowledge (8'h40 with seven-bit addressing, 8'hE0) with zero bytes left issues STOP with done and errCode 0.
- R7: On 8'h40/8'hE0 with bytes left, a control-only write follows. Status 8'h50 captures ctlRdData on rxByte with rxValid and decrements the remaining count. The ack bit written, and all later ones, is 0 once one byte remains or an abort is pending.
- R8: Status 8'h58 captures the final byte with rxValid and issues STOP with done.
- R9: Status 8'h20, 8'h30 or 8'h48 issues STOP with done and errCode 1 (no device).
- R10: Any other status while busy issues STOP with done, pulses ctlSoftRst and sets errCode 2 (I/O error).
- R11: A status event while idle, with no start request in the same cycle, issues a STOP control write without done and leaves errCode unchanged.
- R12: done is high only in the cycle of a STOP control write. errCode stays stable from then until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| xferStart | input | 1 | Begin a message (accepted while idle) |
| devAddr | input | 10 | Target device address |
| tenBit | input | 1 | Ten-bit addressing |
| readDir | input | 1 | 1 = read, 0 = write |
| byteCount | input | CNT_W | Number of data bytes |
| abortReq | input | 1 | Request early end of the message |
| txByte | input | 8 | Next byte to write (head of host stream) |
| txPop | output | 1 | txByte was consumed |
| ctlEvent | input | 1 | Controller status event strobe |
| ctlStatus | input | 8 | Controller status code |
| ctlRdData | input | 8 | Controller data register contents |
| ctlDataWe | output | 1 | Write strobe for controller data register |
| ctlDataOut | output | 8 | Byte written to controller data register |
| ctlCtrlWe | output | 1 | Write strobe for controller control word |
| ctlCtrlOut | output | 4 | Control word {enable, start, stop, ack} |
| ctlSoftRst | output | 1 | Controller soft reset pulse |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | rxByte updated this cycle |
| done | output | 1 | Message finished |
| errCode | output | 2 | 0 ok, 1 no device, 2 I/O error |
| busy | output | 1 | Message in progress |

## Verification
The hardest case to reach is an abort that meets the byte-position guard. An abort raised before any data byte leaves still lets one byte go out. An abort raised after a byte has gone out ends the write at the next acknowledge. The bench raises abortReq at both points in separate write messages and in a multi-byte read, where the abort must clear the ack bit early. The controller side is a scripted status feed, which also reaches the ten-bit address paths, an illegal code, and an event that arrives with no message active. A behavioural model predicts every output on every cycle.

// File: rtl/i2c_msg_seq_pkg.sv
package i2c_msg_seq_pkg;
  localparam int ADDR_W = 10;
  localparam int CTL_W  = 4;
  localparam int CB_ACK = 0, CB_STOP = 1, CB_START = 2, CB_EN = 3;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_WADDR   = 8'h18;
  localparam logic [7:0] ST_WANACK  = 8'h20;
  localparam logic [7:0] ST_WDATA   = 8'h28;
  localparam logic [7:0] ST_WDNACK  = 8'h30;
  localparam logic [7:0] ST_RADDR   = 8'h40;
  localparam logic [7:0] ST_RANACK  = 8'h48;
  localparam logic [7:0] ST_RDATA   = 8'h50;
  localparam logic [7:0] ST_RLAST   = 8'h58;
  localparam logic [7:0] ST_WADDR2  = 8'hD0;
  localparam logic [7:0] ST_RADDR2  = 8'hE0;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_NODEV = 2'd1;
  localparam logic [1:0] ERR_IO    = 2'd2;

  typedef enum logic {SQ_IDLE, SQ_RUN} seqState_e;

  typedef struct packed {
    logic       load;
    logic       sendA1;
    logic       sendA2;
    logic       sendTx;
    logic       capRx;
    logic       ctlOnly;
    logic       clrAck;
    logic       stop;
    logic       fin;
    logic       sRst;
    logic       setErr;
    logic [1:0] err;
  } seqStrobe_t;
endpackage

// File: rtl/i2c_msg_seq_ctrl.sv
module i2c_msg_seq_ctrl
  import i2c_msg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferStart,
  input  logic       abortReq,
  input  logic       ctlEvent,
  input  logic [7:0] ctlStatus,
  input  logic       tenMode,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       cntTwo,
  input  logic       posNz,
  output seqStrobe_t stb,
  output logic       busy
);
  seqState_e state;
  logic abortPend, abortNow, wrAck, rdAck;

  assign busy     = (state == SQ_RUN);
  assign abortNow = abortPend | abortReq;

  always_comb begin
    stb   = '0;
    wrAck = 1'b0;
    rdAck = 1'b0;
    if (!busy) begin
      if (xferStart)     stb.load = 1'b1;
      else if (ctlEvent) stb.stop = 1'b1;
    end else if (ctlEvent) begin
      case (ctlStatus)
        ST_START, ST_RSTART: stb.sendA1 = 1'b1;
        ST_WADDR:            if (tenMode) stb.sendA2 = 1'b1; else wrAck = 1'b1;
        ST_WADDR2, ST_WDATA: wrAck = 1'b1;
        ST_RADDR:            if (tenMode) stb.sendA2 = 1'b1; else rdAck = 1'b1;
        ST_RADDR2:           rdAck = 1'b1;
        ST_RDATA: begin
          stb.capRx   = 1'b1;
          stb.ctlOnly = 1'b1;
          stb.clrAck  = cntTwo | abortNow;
        end
        ST_RLAST: begin
          stb.capRx = 1'b1;
          stb.stop  = 1'b1;
          stb.fin   = 1'b1;
        end
        ST_WANACK, ST_WDNACK, ST_RANACK: begin
          stb.stop   = 1'b1;
          stb.fin    = 1'b1;
          stb.setErr = 1'b1;
          stb.err    = ERR_NODEV;
        end
        default: begin
          stb.stop   = 1'b1;
          stb.fin    = 1'b1;
          stb.sRst   = 1'b1;
          stb.setErr = 1'b1;
          stb.err    = ERR_IO;
        end
      endcase
      if (wrAck) begin
        if (cntZero || (abortNow && posNz)) begin
          stb.stop = 1'b1;
          stb.fin  = 1'b1;
        end else begin
          stb.sendTx = 1'b1;
        end
      end
      if (rdAck) begin
        if (cntZero) begin
          stb.stop = 1'b1;
          stb.fin  = 1'b1;
        end else begin
          stb.ctlOnly = 1'b1;
          stb.clrAck  = cntOne | abortNow;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      abortPend <= 1'b0;
    end else begin
      if (stb.load)                state <= SQ_RUN;
      else if (stb.fin)            state <= SQ_IDLE;
      if (stb.load)                abortPend <= 1'b0;
      else if (busy && abortReq)   abortPend <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_msg_seq_dp.sv
module i2c_msg_seq_dp
  import i2c_msg_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              tenBit,
  input  logic              readDir,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [7:0]        txByte,
  input  logic [7:0]        ctlRdData,
  output logic              txPop,
  output logic              ctlDataWe,
  output logic [7:0]        ctlDataOut,
  output logic              ctlCtrlWe,
  output logic [CTL_W-1:0]  ctlCtrlOut,
  output logic              ctlSoftRst,
  output logic [7:0]        rxByte,
  output logic              rxValid,
  output logic              done,
  output logic [1:0]        errCode,
  output logic              tenMode,
  output logic              cntZero,
  output logic              cntOne,
  output logic              cntTwo,
  output logic              posNz
);
  logic [7:0]       addr1, addr2, hdrByte, outByte;
  logic [CNT_W-1:0] cnt;
  logic             ackBit, nextAck;

  assign cntZero = (cnt == '0);
  assign cntOne  = (cnt == CNT_W'(1));
  assign cntTwo  = (cnt == CNT_W'(2));
  assign nextAck = ackBit & ~stb.clrAck;
  assign hdrByte = tenBit ? {5'b11110, devAddr[9:8], readDir}
                          : {devAddr[6:0], readDir};
  assign outByte = stb.sendA1 ? addr1 : (stb.sendA2 ? addr2 : txByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr1 <= '0; addr2 <= '0; tenMode <= 1'b0; cnt <= '0; posNz <= 1'b0;
      ackBit <= 1'b0; txPop <= 1'b0; ctlDataWe <= 1'b0; ctlDataOut <= '0;
      ctlCtrlWe <= 1'b0; ctlCtrlOut <= '0; ctlSoftRst <= 1'b0;
      rxByte <= '0; rxValid <= 1'b0; done <= 1'b0; errCode <= ERR_NONE;
    end else begin
      txPop      <= stb.sendTx;
      rxValid    <= stb.capRx;
      done       <= stb.fin;
      ctlSoftRst <= stb.sRst;
      ctlDataWe  <= stb.sendA1 | stb.sendA2 | stb.sendTx;
      ctlCtrlWe  <= stb.load | stb.sendA1 | stb.sendA2 | stb.sendTx | stb.ctlOnly | stb.stop;
      if (stb.load) begin
        addr1      <= hdrByte;
        addr2      <= devAddr[7:0];
        tenMode    <= tenBit;
        cnt        <= byteCount;
        posNz      <= 1'b0;
        ackBit     <= 1'b1;
        errCode    <= ERR_NONE;
        ctlCtrlOut <= 4'b1101;
      end
      if (stb.sendA1 | stb.sendA2 | stb.sendTx) begin
        ctlDataOut <= outByte;
        ctlCtrlOut <= {1'b1, 1'b0, 1'b0, ackBit};
      end
      if (stb.sendTx) begin
        cnt   <= cnt - CNT_W'(1);
        posNz <= 1'b1;
      end
      if (stb.capRx) begin
        rxByte <= ctlRdData;
        if (!stb.stop) cnt <= cnt - CNT_W'(1);
      end
      if (stb.ctlOnly) begin
        ackBit     <= nextAck;
        ctlCtrlOut <= {1'b1, 1'b0, 1'b0, nextAck};
      end
      if (stb.stop) ctlCtrlOut <= {1'b1, 1'b0, 1'b1, ackBit};
      if (stb.setErr) errCode <= stb.err;
    end
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2c_msg_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              tenBit,
  input  logic              readDir,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic              abortReq,
  input  logic [7:0]        txByte,
  output logic              txPop,
  input  logic              ctlEvent,
  input  logic [7:0]        ctlStatus,
  input  logic [7:0]        ctlRdData,
  output logic              ctlDataWe,
  output logic [7:0]        ctlDataOut,
  output logic              ctlCtrlWe,
  output logic [CTL_W-1:0]  ctlCtrlOut,
  output logic              ctlSoftRst,
  output logic [7:0]        rxByte,
  output logic              rxValid,
  output logic              done,
  output logic [1:0]        errCode,
  output logic              busy
);
  seqStrobe_t stb;
  logic tenMode, cntZero, cntOne, cntTwo, posNz;

  i2c_msg_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .abortReq(abortReq),
    .ctlEvent(ctlEvent), .ctlStatus(ctlStatus), .tenMode(tenMode),
    .cntZero(cntZero), .cntOne(cntOne), .cntTwo(cntTwo), .posNz(posNz),
    .stb(stb), .busy(busy)
  );

  i2c_msg_seq_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .devAddr(devAddr), .tenBit(tenBit),
    .readDir(readDir), .byteCount(byteCount), .txByte(txByte),
    .ctlRdData(ctlRdData), .txPop(txPop), .ctlDataWe(ctlDataWe),
    .ctlDataOut(ctlDataOut), .ctlCtrlWe(ctlCtrlWe), .ctlCtrlOut(ctlCtrlOut),
    .ctlSoftRst(ctlSoftRst), .rxByte(rxByte), .rxValid(rxValid), .done(done),
    .errCode(errCode), .tenMode(tenMode), .cntZero(cntZero), .cntOne(cntOne),
    .cntTwo(cntTwo), .posNz(posNz)
  );
endmodule

// File: rtl/i2c_msg_seq_chk.sv
module i2c_msg_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xferStart,
  input logic       ctlEvent,
  input logic       busy,
  input logic       txPop,
  input logic       rxValid,
  input logic       ctlDataWe,
  input logic       ctlCtrlWe,
  input logic [3:0] ctlCtrlOut,
  input logic       ctlSoftRst,
  input logic       done,
  input logic [1:0] errCode
);
  // R12
  done_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (ctlCtrlWe && ctlCtrlOut[1]));
  // R10
  srst_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlSoftRst |-> (done && errCode == 2'd2));
  // R3
  start_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferStart && !busy) |=> (ctlCtrlWe && ctlCtrlOut == 4'b1101 && busy && errCode == 2'd0));
  // R11
  idle_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlEvent && !busy && !xferStart) |=> (ctlCtrlWe && ctlCtrlOut[1] && !done));
  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xferStart && !busy) |=> ($stable(errCode) || done));
  // R5
  pop_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> (ctlDataWe && ctlCtrlWe && !done));
  // R7
  rx_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (ctlCtrlWe && !ctlDataWe));
  // R4
  data_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlDataWe |-> (ctlCtrlWe && !ctlCtrlOut[1] && !ctlCtrlOut[2]));
endmodule

bind i2c_msg_seq i2c_msg_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .xferStart(xferStart), .ctlEvent(ctlEvent),
  .busy(busy), .txPop(txPop), .rxValid(rxValid), .ctlDataWe(ctlDataWe),
  .ctlCtrlWe(ctlCtrlWe), .ctlCtrlOut(ctlCtrlOut), .ctlSoftRst(ctlSoftRst),
  .done(done), .errCode(errCode)
);

// File: tb/i2c_msg_seq_tb.sv
module i2c_msg_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rstN = 1'b0;
  logic xferStart = 0, tenBit = 0, readDir = 0, abortReq = 0, ctlEvent = 0;
  logic [9:0] devAddr = '0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0] txByte = '0, ctlStatus = '0, ctlRdData = '0;
  logic txPop, ctlDataWe, ctlCtrlWe, ctlSoftRst, rxValid, done, busy;
  logic [7:0] ctlDataOut, rxByte;
  logic [3:0] ctlCtrlOut;
  logic [1:0] errCode;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_msg_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .devAddr(devAddr),
    .tenBit(tenBit), .readDir(readDir), .byteCount(byteCount),
    .abortReq(abortReq), .txByte(txByte), .txPop(txPop), .ctlEvent(ctlEvent),
    .ctlStatus(ctlStatus), .ctlRdData(ctlRdData), .ctlDataWe(ctlDataWe),
    .ctlDataOut(ctlDataOut), .ctlCtrlWe(ctlCtrlWe), .ctlCtrlOut(ctlCtrlOut),
    .ctlSoftRst(ctlSoftRst), .rxByte(rxByte), .rxValid(rxValid), .done(done),
    .errCode(errCode), .busy(busy)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  string curReq = "R3";
  logic [7:0] txQ[$];

  // behavioural reference state
  bit mActive, mTen, mAck, mAbort;
  int mRemain, mSent;
  logic [7:0] mFirst, mSecond;
  logic eDataWe, eCtrlWe, eSRst, eTxPop, eRxValid, eDone, eBusy;
  logic [7:0] eDataOut, eRxByte;
  logic [3:0] eCtrlOut;
  logic [1:0] eErr;

  task automatic mStop(input bit fin);
    eCtrlWe = 1; eCtrlOut = {1'b1, 1'b0, 1'b1, mAck};
    eDone = fin;
    if (fin) mActive = 0;
  endtask

  task automatic mSendByte(input logic [7:0] b);
    eDataWe = 1; eDataOut = b; eCtrlWe = 1; eCtrlOut = {3'b100, mAck};
  endtask

  task automatic mCtl(input bit clr);
    if (clr) mAck = 0;
    eCtrlWe = 1; eCtrlOut = {3'b100, mAck};
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mTen = 0; mAck = 0; mAbort = 0; mRemain = 0; mSent = 0;
      eDataWe = 0; eCtrlWe = 0; eSRst = 0; eTxPop = 0; eRxValid = 0; eDone = 0;
      eDataOut = 0; eRxByte = 0; eCtrlOut = 0; eErr = 0;
    end else begin
      bit ab;
      eDataWe = 0; eCtrlWe = 0; eSRst = 0; eTxPop = 0; eRxValid = 0; eDone = 0;
      ab = mAbort || abortReq;
      if (!mActive) begin
        if (xferStart) begin
          mActive = 1; mTen = tenBit; mRemain = int'(byteCount); mSent = 0;
          mAck = 1; mAbort = 0; eErr = 0;
          mFirst = tenBit ? (8'hF0 | {5'b0, devAddr[9:8], 1'b0} | {7'b0, readDir})
                          : {devAddr[6:0], readDir};
          mSecond = devAddr[7:0];
          eCtrlWe = 1; eCtrlOut = 4'b1101;
        end else if (ctlEvent) mStop(0);
      end else begin
        if (abortReq) mAbort = 1;
        if (ctlEvent) begin
          bit wr, rd;
          wr = 0; rd = 0;
          case (ctlStatus)
            8'h08, 8'h10: mSendByte(mFirst);
            8'h18: if (mTen) mSendByte(mSecond); else wr = 1;
            8'hD0, 8'h28: wr = 1;
            8'h40: if (mTen) mSendByte(mSecond); else rd = 1;
            8'hE0: rd = 1;
            8'h50: begin
              eRxValid = 1; eRxByte = ctlRdData; mRemain--;
              mCtl(mRemain == 1 || ab);
            end
            8'h58: begin eRxValid = 1; eRxByte = ctlRdData; mStop(1); end
            8'h20, 8'h30, 8'h48: begin mStop(1); eErr = 2'd1; end
            default: begin mStop(1); eSRst = 1; eErr = 2'd2; end
          endcase
          if (wr) begin
            if (mRemain == 0 || (ab && mSent != 0)) mStop(1);
            else begin mSendByte(txByte); eTxPop = 1; mRemain--; mSent++; end
          end
          if (rd) begin
            if (mRemain == 0) mStop(1);
            else mCtl(mRemain == 1 || ab);
          end
        end
      end
      eBusy = mActive;
    end
  end

  task automatic cmp(input string nm, input int act, input int exp);
    if (act != exp) begin
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", curReq, nm, act, exp, $time);
      miscompares++;
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      vectors++;
      cmp("ctlDataWe", ctlDataWe, eDataWe);
      if (eDataWe) cmp("ctlDataOut", ctlDataOut, eDataOut);
      cmp("ctlCtrlWe", ctlCtrlWe, eCtrlWe);
      if (eCtrlWe) cmp("ctlCtrlOut", ctlCtrlOut, eCtrlOut);
      cmp("ctlSoftRst", ctlSoftRst, eSRst);
      cmp("txPop", txPop, eTxPop);
      cmp("rxValid", rxValid, eRxValid);
      if (eRxValid) cmp("rxByte", rxByte, eRxByte);
      cmp("done", done, eDone);
      cmp("errCode", errCode, eErr);
      cmp("busy", busy, mActive);
      if (eTxPop && txQ.size() > 0) void'(txQ.pop_front());
      txByte = (txQ.size() > 0) ? txQ[0] : 8'h00;
    end
    if (cycles > WATCHDOG) begin
      $display("FAIL watchdog %s: actual hung expected finish", curReq);
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(input logic [9:0] a, input bit ten, input bit rd, input int n);
    @(negedge clk);
    devAddr = a; tenBit = ten; readDir = rd; byteCount = CNT_W'(n); xferStart = 1;
    @(negedge clk);
    xferStart = 0;
    idle(1);
  endtask

  task automatic ev(input logic [7:0] st, input logic [7:0] d);
    @(negedge clk);
    ctlEvent = 1; ctlStatus = st; ctlRdData = d;
    @(negedge clk);
    ctlEvent = 0;
    idle(2);
  endtask

  initial begin
    idle(3);
    // R3: reset state
    vectors++;
    if (busy !== 0 || done !== 0 || errCode !== 0 || ctlCtrlWe !== 0) begin
      $display("FAIL R3 reset: actual busy=%b done=%b err=%0d expected 0 0 0", busy, done, errCode);
      miscompares++;
    end
    @(negedge clk) rstN = 1;
    idle(2);

    // R1 R4 R5 seven-bit write of two bytes
    curReq = "R1"; txQ = '{8'hA1, 8'hB2}; txByte = 8'hA1;
    go(10'h05A, 0, 0, 2);
    ev(8'h08, 0);
    curReq = "R5"; ev(8'h18, 0); ev(8'h28, 0); ev(8'h28, 0);
    idle(3);

    // R7 R8 seven-bit read of three bytes, repeated start code
    curReq = "R7"; go(10'h033, 0, 1, 3);
    curReq = "R4"; ev(8'h10, 0);
    curReq = "R7"; ev(8'h40, 0); ev(8'h50, 8'h11); ev(8'h50, 8'h22);
    curReq = "R8"; ev(8'h58, 8'h33);
    idle(3);

    // R6 probe
    curReq = "R6"; go(10'h050, 0, 1, 0);
    ev(8'h08, 0); ev(8'h40, 0);
    idle(3);

    // R2 ten-bit write of one byte
    curReq = "R2"; txQ = '{8'h5C}; txByte = 8'h5C;
    go(10'h2C5, 1, 0, 1);
    ev(8'h08, 0); ev(8'h18, 0); ev(8'hD0, 0);
    curReq = "R5"; ev(8'h28, 0);
    idle(3);

    // R2 R7 ten-bit read of one byte
    curReq = "R2"; go(10'h1A7, 1, 1, 1);
    ev(8'h08, 0); ev(8'h40, 0);
    curReq = "R7"; ev(8'hE0, 0);
    curReq = "R8"; ev(8'h58, 8'h9E);
    idle(3);

    // R9 no device, then R12 hold
    curReq = "R9"; go(10'h011, 0, 0, 2);
    ev(8'h08, 0); ev(8'h20, 0);
    curReq = "R12"; idle(6);

    // R11 event while idle
    curReq = "R11"; ev(8'h28, 0); ev(8'hF8, 0);
    idle(3);

    // R10 illegal status
    curReq = "R10"; go(10'h022, 0, 1, 2);
    ev(8'h08, 0); ev(8'hF8, 0);
    curReq = "R12"; idle(5);

    // R5 abort after one byte sent
    curReq = "R5"; txQ = '{8'h01, 8'h02, 8'h03}; txByte = 8'h01;
    go(10'h044, 0, 0, 3);
    ev(8'h08, 0); ev(8'h18, 0);
    @(negedge clk) abortReq = 1; @(negedge clk) abortReq = 0;
    ev(8'h28, 0);
    idle(3);

    // R5 abort before any byte: one byte still leaves
    txQ = '{8'h0A, 8'h0B, 8'h0C, 8'h0D}; txByte = 8'h0A;
    go(10'h045, 0, 0, 4);
    @(negedge clk) abortReq = 1; @(negedge clk) abortReq = 0;
    ev(8'h08, 0); ev(8'h18, 0); ev(8'h28, 0);
    idle(3);

    // R7 abort during read clears ack early; R3 start while busy ignored
    curReq = "R7"; go(10'h046, 0, 1, 4);
    ev(8'h08, 0);
    curReq = "R3"; @(negedge clk) begin xferStart = 1; devAddr = 10'h3FF; end
    @(negedge clk) xferStart = 0;
    curReq = "R7"; @(negedge clk) abortReq = 1; @(negedge clk) abortReq = 0;
    ev(8'h40, 0); ev(8'h50, 8'h44);
    curReq = "R8"; ev(8'h58, 8'h55);
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule